// File: doc/BRIEF.md
# Write Protection and Write Cycle Controller

This block guards every write into a serial non-volatile memory. It keeps the status register (busy flag, write-enable latch, a two-bit block-protect field and a bit that arms the hardware protect pin) and decides, for each decoded write command, whether it is granted or refused. Granted status and data writes are held pending until chip select is released. They then run a self-timed internal write cycle whose length in clock cycles is a parameter.

The serial front end decodes opcodes and presents them as one-cycle command strobes while chip select is low. It reads the status byte back from `status_o`. The storage array sits behind a single write strobe plus a latched address, which pulses when a data cycle completes. Hardware protection comes from the active-low protect pin, which counts only while the pin-enable status bit is set. If the pin drops before a pending status write has started, that write is cancelled. Once the cycle has started, the pin no longer affects it.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset `status_o` is 0, and `busy_o`, `grant_o`, `deny_o` and `arr_wr_o` are 0.
- R2: Command codes on `cmd_i` are 00 write-enable, 01 write-disable, 10 status write, 11 data write. A granted write-enable sets the latch (status bit 1) and a granted write-disable clears it, visible the cycle after the command.
- R3: A status write or data write issued while the latch is clear is denied and changes no status bit.
- R4: A granted status write starts its cycle on the first clock with `cs_ni` high. `busy_o` (status bit 0) is then high for exactly WR_CYCLES cycles, and the latch stays set throughout. When the cycle ends, status bit 7 (pin enable) and bits 3:2 (block protect) take the same bits of `data_i`, and the latch clears. Other bits of `data_i` are ignored.
- R5: With status bit 7 at 1 and `wp_ni` low, a status write is denied.
- R6: With status bit 7 at 0, `wp_ni` is ignored, and a status write with the pin low is granted and completes.
- R7: If `wp_ni` goes low while a granted status write is pending (status bit 7 at 1, `cs_ni` still low), the write is cancelled: `deny_o` pulses, no cycle runs, and the status bits are unchanged.
- R8: `wp_ni` falling after a status cycle has started has no effect; the new value is loaded.
- R9: Block protect encoding: 00 none, 01 addresses whose top two bits are 11, 10 addresses whose top bit is 1, 11 all addresses. A data write to a protected address is denied.
- R10: A granted data write runs a WR_CYCLES busy cycle after `cs_ni` rises. On the clock where busy falls, `arr_wr_o` pulses for one cycle with `arr_addr_o` equal to the command's address, and the latch clears.
- R11: While busy, or while a granted write is pending, every command is denied and has no effect on the status bits.
- R12: Each command strobe with `cs_ni` low gets exactly one of `grant_o`/`deny_o` on the next cycle. A strobe with `cs_ni` high gets neither and is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low; its release starts a pending write |
| wp_ni | input | 1 | Hardware write-protect pin, active low |
| cmd_valid_i | input | 1 | One-cycle decoded command strobe |
| cmd_i | input | 2 | Command code |
| addr_i | input | AW | Array address of a data write |
| data_i | input | 8 | New status byte of a status write |
| busy_o | output | 1 | Internal write cycle in progress |
| grant_o | output | 1 | Previous command accepted |
| deny_o | output | 1 | Previous command refused, or pending status write cancelled |
| status_o | output | 8 | Status register readout |
| arr_wr_o | output | 1 | Array write strobe at data cycle end |
| arr_addr_o | output | AW | Address of the completed data write |

## Verification
Status writes are tried with the pin enable clear and set, and with the pin high, low before the command, low during the pending window and low after the cycle starts. These cases separate the pin gating from the abort window and from the committed cycle. Data writes are driven at addresses just inside and just outside each protected region for every block-protect code, which distinguishes the quarter, half and whole-array decodes. Commands are also issued during busy, during the pending window and with chip select high, to show that none of them reaches the latch.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  typedef enum logic [1:0] {
    CMD_WEN   = 2'b00,
    CMD_WDIS  = 2'b01,
    CMD_WSTAT = 2'b10,
    CMD_WDATA = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    BP_NONE = 2'b00,
    BP_QTR  = 2'b01,
    BP_HALF = 2'b10,
    BP_ALL  = 2'b11
  } bp_e;

  localparam int unsigned SR_BUSY = 0;
  localparam int unsigned SR_WEL  = 1;
  localparam int unsigned SR_BP_LO = 2;
  localparam int unsigned SR_PEN  = 7;
endpackage

// File: rtl/wprot_range_chk.sv
module wprot_range_chk
  import wprot_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic [1:0]    bp_i,
  input  logic [AW-1:0] addr_i,
  output logic          prot_o
);
  always_comb begin
    unique case (bp_e'(bp_i))
      BP_NONE: prot_o = 1'b0;
      BP_QTR:  prot_o = &addr_i[AW-1:AW-2];
      BP_HALF: prot_o = addr_i[AW-1];
      default: prot_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wprot_cycle_timer.sv
module wprot_cycle_timer #(
  parameter int unsigned WR_CYCLES = 200000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(WR_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(WR_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign done_o = busy_q && (cnt_q == '0);
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_LOAD;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wprot_status_reg.sv
module wprot_status_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_wel_i,
  input  logic       clr_wel_i,
  input  logic       load_i,
  input  logic       load_pen_i,
  input  logic [1:0] load_bp_i,
  output logic       wel_o,
  output logic       pen_o,
  output logic [1:0] bp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_o <= 1'b0;
      pen_o <= 1'b0;
      bp_o  <= 2'b00;
    end else begin
      if (clr_wel_i)      wel_o <= 1'b0;
      else if (set_wel_i) wel_o <= 1'b1;
      if (load_i) begin
        pen_o <= load_pen_i;
        bp_o  <= load_bp_i;
      end
    end
  end
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wprot_pkg::*;
#(
  parameter int unsigned AW        = 10,
  parameter int unsigned WR_CYCLES = 200000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          wp_ni,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          busy_o,
  output logic          grant_o,
  output logic          deny_o,
  output logic [7:0]    status_o,
  output logic          arr_wr_o,
  output logic [AW-1:0] arr_addr_o
);
  cmd_e          cmd;
  logic          wel, pen, prot, busy, done;
  logic [1:0]    bp;
  logic          pend_sr_q, pend_wr_q, cyc_sr_q;
  logic          hold_pen_q;
  logic [1:0]    hold_bp_q;
  logic [AW-1:0] hold_addr_q;
  logic          grant_q, deny_q, arr_wr_q;
  logic          strobe, locked, ok, abort, start;

  assign cmd    = cmd_e'(cmd_i);
  assign strobe = cmd_valid_i && !cs_ni;
  assign locked = busy || pend_sr_q || pend_wr_q;

  wprot_range_chk #(.AW(AW)) u_range (
    .bp_i   (bp),
    .addr_i (addr_i),
    .prot_o (prot)
  );

  // pin counts only when armed by the pin-enable bit
  always_comb begin
    ok = 1'b0;
    if (!locked) begin
      unique case (cmd)
        CMD_WEN, CMD_WDIS: ok = 1'b1;
        CMD_WSTAT:         ok = wel && !(pen && !wp_ni);
        default:           ok = wel && !prot;
      endcase
    end
  end

  assign abort = pend_sr_q && pen && !wp_ni;
  assign start = (pend_sr_q || pend_wr_q) && cs_ni && !abort;

  wprot_cycle_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_o  (busy),
    .done_o  (done)
  );

  wprot_status_reg u_sreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_wel_i  (strobe && ok && cmd == CMD_WEN),
    .clr_wel_i  ((strobe && ok && cmd == CMD_WDIS) || done),
    .load_i     (done && cyc_sr_q),
    .load_pen_i (hold_pen_q),
    .load_bp_i  (hold_bp_q),
    .wel_o      (wel),
    .pen_o      (pen),
    .bp_o       (bp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_sr_q   <= 1'b0;
      pend_wr_q   <= 1'b0;
      cyc_sr_q    <= 1'b0;
      hold_pen_q  <= 1'b0;
      hold_bp_q   <= 2'b00;
      hold_addr_q <= '0;
      grant_q     <= 1'b0;
      deny_q      <= 1'b0;
      arr_wr_q    <= 1'b0;
    end else begin
      grant_q  <= strobe && ok;
      deny_q   <= (strobe && !ok) || abort;
      arr_wr_q <= done && !cyc_sr_q;
      if (strobe && ok && cmd == CMD_WSTAT) begin
        pend_sr_q  <= 1'b1;
        hold_pen_q <= data_i[SR_PEN];
        hold_bp_q  <= data_i[SR_BP_LO +: 2];
      end else if (abort || start) begin
        pend_sr_q <= 1'b0;
      end
      if (strobe && ok && cmd == CMD_WDATA) begin
        pend_wr_q   <= 1'b1;
        hold_addr_q <= addr_i;
      end else if (start) begin
        pend_wr_q <= 1'b0;
      end
      if (start) cyc_sr_q <= pend_sr_q;
    end
  end

  assign busy_o     = busy;
  assign grant_o    = grant_q;
  assign deny_o     = deny_q;
  assign arr_wr_o   = arr_wr_q;
  assign arr_addr_o = hold_addr_q;
  assign status_o   = {pen, 3'b000, bp, wel, busy};
endmodule

// File: rtl/wprot_ctrl_chk.sv
module wprot_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       cmd_valid_i,
  input logic       busy_o,
  input logic       grant_o,
  input logic       deny_o,
  input logic [7:0] status_o,
  input logic       arr_wr_o
);
  p_resp_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && deny_o));

  p_resp_next_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !cs_ni) |=> (grant_o || deny_o));

  p_wel_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> status_o[1]);

  p_wel_clr_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !status_o[1]);

  p_busy_deny_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !cs_ni && busy_o) |=> deny_o);

  p_status_frozen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o ##1 busy_o) |-> $stable(status_o[7:1]));

  p_arr_wr_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_wr_o |-> ($past(busy_o) && !busy_o));
endmodule

bind wprot_ctrl wprot_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .cmd_valid_i (cmd_valid_i),
  .busy_o      (busy_o),
  .grant_o     (grant_o),
  .deny_o      (deny_o),
  .status_o    (status_o),
  .arr_wr_o    (arr_wr_o)
);

// File: tb/wprot_ctrl_bench.sv
module wprot_ctrl_bench;
  localparam int unsigned AW = 10;
  localparam int unsigned WR = 8;
  localparam logic [1:0] WEN = 2'b00, WDIS = 2'b01, WSTAT = 2'b10, WDATA = 2'b11;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, wp_ni = 1'b1, cmd_valid = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic [AW-1:0] addr = '0, arr_addr;
  logic [7:0] data = '0, status;
  logic busy, grant, deny, arr_wr;
  int n_chk = 0, n_fail = 0;
  logic g_s, d_s;

  always #5 clk = ~clk;

  wprot_ctrl #(.AW(AW), .WR_CYCLES(WR)) u_wprot_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .wp_ni(wp_ni),
    .cmd_valid_i(cmd_valid), .cmd_i(cmd), .addr_i(addr), .data_i(data),
    .busy_o(busy), .grant_o(grant), .deny_o(deny), .status_o(status),
    .arr_wr_o(arr_wr), .arr_addr_o(arr_addr)
  );

  task automatic check(input bit cond, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] c, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_ni = 1'b0; cmd_valid = 1'b1; cmd = c; addr = a; data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    g_s = grant; d_s = deny;
  endtask

  // release chip select, then count busy cycles; optionally drop pin after start
  task automatic run_cycle(input string req, input bit drop_wp, output logic arr_seen);
    int n = 0;
    @(negedge clk); cs_ni = 1'b1;
    @(negedge clk);
    if (drop_wp) wp_ni = 1'b0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    arr_seen = arr_wr;
    check(n == WR, req, "busy length", n, WR);
  endtask

  task automatic write_status(input logic [7:0] d, input string req);
    logic a;
    issue(WEN, '0, '0);
    issue(WSTAT, '0, d);
    check(g_s == 1'b1, req, "status write grant", g_s, 1);
    run_cycle(req, 1'b0, a);
  endtask

  task automatic t_reset;
    check(status == 8'h00, "R1", "status", status, 0);
    check({busy, grant, deny, arr_wr} == 4'b0, "R1", "outputs", {busy, grant, deny, arr_wr}, 0);
  endtask

  task automatic t_wel;
    issue(WEN, '0, '0);
    check(g_s && status[1], "R2", "wel after enable", status, 8'h02);
    issue(WDIS, '0, '0);
    check(g_s && !status[1], "R2", "wel after disable", status, 8'h00);
  endtask

  task automatic t_no_wel;
    issue(WSTAT, '0, 8'h8C);
    check(d_s && !g_s, "R3", "status write no wel deny", d_s, 1);
    issue(WDATA, 10'h005, '0);
    check(d_s && !g_s, "R3", "data write no wel deny", d_s, 1);
    @(negedge clk); cs_ni = 1'b1; @(negedge clk); @(negedge clk);
    check(status == 8'h00 && !busy, "R3", "status unchanged", status, 0);
  endtask

  task automatic t_status_write;
    write_status(8'h7B, "R4");  // only bits 3:2 of 0x7B land (10)
    check(status == 8'h08, "R4", "status loaded, wel cleared", status, 8'h08);
    write_status(8'h00, "R4");
    check(status == 8'h00, "R4", "status cleared", status, 0);
  endtask

  task automatic t_wp_gating;
    wp_ni = 1'b0;
    write_status(8'h84, "R6");
    check(status == 8'h84, "R6", "pin ignored when pen=0", status, 8'h84);
    issue(WEN, '0, '0);
    issue(WSTAT, '0, 8'h00);
    check(d_s && !g_s, "R5", "pin blocks when pen=1", d_s, 1);
    @(negedge clk); cs_ni = 1'b1; @(negedge clk); @(negedge clk);
    check(status == 8'h86, "R5", "status kept, wel set", status, 8'h86);
    wp_ni = 1'b1;
    issue(WDIS, '0, '0);
  endtask

  task automatic t_abort;
    issue(WEN, '0, '0);
    issue(WSTAT, '0, 8'h00);
    check(g_s, "R7", "pending grant", g_s, 1);
    wp_ni = 1'b0;
    @(negedge clk);
    check(deny == 1'b1, "R7", "abort deny pulse", deny, 1);
    cs_ni = 1'b1;
    @(negedge clk); @(negedge clk);
    check(!busy && status[7:2] == 6'b100001, "R7", "no cycle, bits kept", status, 8'h86);
    wp_ni = 1'b1;
    issue(WDIS, '0, '0);
  endtask

  task automatic t_late_wp;
    logic a;
    issue(WEN, '0, '0);
    issue(WSTAT, '0, 8'h88);
    run_cycle("R8", 1'b1, a);
    check(status == 8'h88, "R8", "late pin ignored", status, 8'h88);
    wp_ni = 1'b1;
    write_status(8'h00, "R8");
  endtask

  task automatic t_protect;
    logic a;
    write_status(8'h04, "R9");
    issue(WEN, '0, '0);
    issue(WDATA, 10'h300, '0);
    check(d_s, "R9", "quarter: 0x300 denied", d_s, 1);
    issue(WDATA, 10'h2FF, '0);
    check(g_s, "R9", "quarter: 0x2FF granted", g_s, 1);
    run_cycle("R9", 1'b0, a);
    write_status(8'h08, "R9");
    issue(WEN, '0, '0);
    issue(WDATA, 10'h200, '0);
    check(d_s, "R9", "half: 0x200 denied", d_s, 1);
    issue(WDATA, 10'h1FF, '0);
    check(g_s, "R9", "half: 0x1FF granted", g_s, 1);
    run_cycle("R9", 1'b0, a);
    write_status(8'h0C, "R9");
    issue(WEN, '0, '0);
    issue(WDATA, 10'h000, '0);
    check(d_s, "R9", "all: 0x000 denied", d_s, 1);
    issue(WDIS, '0, '0);
    write_status(8'h00, "R9");
  endtask

  task automatic t_data_write;
    logic a;
    issue(WEN, '0, '0);
    issue(WDATA, 10'h3A5, '0);
    check(g_s, "R10", "grant", g_s, 1);
    run_cycle("R10", 1'b0, a);
    check(a == 1'b1 && arr_addr == 10'h3A5, "R10", "array strobe/addr", arr_addr, 10'h3A5);
    @(negedge clk);
    check(arr_wr == 1'b0 && status[1] == 1'b0, "R10", "strobe one cycle, wel clear", arr_wr, 0);
  endtask

  task automatic t_busy_lock;
    int n = 0;
    issue(WEN, '0, '0);
    issue(WDATA, 10'h010, '0);
    issue(WDIS, '0, '0);
    check(d_s && status[1], "R11", "pending denies disable", status, 8'h02);
    @(negedge clk); cs_ni = 1'b1;
    @(negedge clk);
    issue(WDIS, '0, '0);
    check(d_s && status[1:0] == 2'b11, "R11", "busy denies disable", status, 8'h03);
    issue(WSTAT, '0, 8'h8C);
    check(d_s && status[7:2] == 6'b0, "R11", "busy denies status write", status, 8'h03);
    cs_ni = 1'b1;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    check(arr_wr && arr_addr == 10'h010, "R11", "original write completes", arr_addr, 10'h010);
  endtask

  task automatic t_cs_high;
    @(negedge clk);
    cs_ni = 1'b1; cmd_valid = 1'b1; cmd = WEN;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(!grant && !deny, "R12", "no response with cs high", {grant, deny}, 0);
    @(negedge clk);
    check(status[1] == 1'b0, "R12", "wel not set", status, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_wel();
    t_no_wel();
    t_status_write();
    t_wp_gating();
    t_abort();
    t_late_wp();
    t_protect();
    t_data_write();
    t_busy_lock();
    t_cs_high();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule